// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address of every beat of one SDRAM read or write burst, one address per clock. A start strobe captures a 9-bit starting column, a 3-bit length code and an ordering bit. From the next cycle on, the block presents the columns of the burst in order, together with a valid flag and a last-beat flag. A memory controller places the block beside its command sequencer and drives the column lines from `col_o` on each cycle where `valid_o` is high.

Bursts of 2, 4 or 8 beats stay inside an aligned block of columns. The upper column bits pick the block, and the low bits step through it in linear or in XOR-interleaved order. A one-beat burst uses the column exactly as given. A full-page burst walks the whole row in linear order, wraps from the top column back to column 0, and runs until a terminate strobe ends it. An illegal length request produces an error pulse and no beats.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, and with no start request, `valid_o`, `last_o` and `err_o` are 0.
- R2: A legal start request sampled on a clock edge makes `valid_o` 1 in the following cycle, with `col_o` equal to the start column (beat 0).
- R3: Length codes are 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8 beats and 3'b111=full page. A fixed-length burst of N beats gives exactly N consecutive valid cycles. `last_o` is 1 only on the Nth beat, and `valid_o` is 0 after it unless a new start is sampled.
- R4: With `ilv_i`=0 and N in {2,4,8}, beat i has the start's upper bits (above log2 N) unchanged and the low log2 N bits equal to (start low bits + i) mod N. Example: start 5, N=8 gives 5,6,7,0,1,2,3,4.
- R5: With `ilv_i`=1 and N in {2,4,8}, beat i has the start's upper bits unchanged and the low log2 N bits equal to the start's low bits XOR i. Example: start 5, N=8 gives 5,4,7,6,1,0,3,2.
- R6: With N=1, the single beat equals the full start column, whatever `ilv_i` is.
- R7: A full-page burst (code 3'b111, `ilv_i`=0) gives beat i = (start + i) mod 512. It never raises `last_o` and continues until it is terminated or restarted.
- R8: `term_i` sampled without `start_i` ends any burst: `valid_o` is 0 from the next cycle. When no burst is running, `term_i` has no effect.
- R9: Codes 3'b100, 3'b101, 3'b110, and 3'b111 with `ilv_i`=1, are illegal. An illegal start raises `err_o` for exactly one cycle, cancels any running burst and issues no beat.
- R10: A start sampled during a burst restarts the sequence from the new start column in the next cycle. Start takes priority over a terminate sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for a new burst |
| start_col_i | input | 9 | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | One-cycle pulse for an illegal start |

## Verification
Two pairs of events can land on the same edge: a start and a terminate, and a new start and the last beat or an error abort of a running burst. The random stimulus raises start and terminate on independent draws during every kind of burst, so both collisions occur many times. A directed case also strobes both on one edge in the middle of a full-page burst. A reference model in the bench applies start-before-terminate priority and expects the new sequence from its first beat in the next cycle, with no gap and no trailing beat of the old burst.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;
endpackage

// File: rtl/col_len_decode.sv
module col_len_decode
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  input  logic             ilv_i,
  output logic             legal_o,
  output logic             full_o,
  output logic [COL_W-1:0] mask_o
);
  always_comb begin
    legal_o = 1'b1;
    full_o  = 1'b0;
    mask_o  = '0;
    unique case (code_i)
      LEN_1:    mask_o = COL_W'(0);
      LEN_2:    mask_o = COL_W'(1);
      LEN_4:    mask_o = COL_W'(3);
      LEN_8:    mask_o = COL_W'(7);
      LEN_PAGE: begin
        mask_o  = '1;
        full_o  = 1'b1;
        legal_o = ~ilv_i;  // page mode is linear only
      end
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/col_beat_ctr.sv
module col_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             legal_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] start_col_i,
  output logic             act_o,
  output logic             err_o,
  output logic             last_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o
);
  logic             act_q, err_q, full_q, ilv_q;
  logic [COL_W-1:0] mask_q, base_q, idx_q;
  logic             at_end;

  assign at_end = ~full_q & (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      mask_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      act_q  <= legal_i;
      err_q  <= ~legal_i;
      full_q <= full_i;
      ilv_q  <= ilv_i;
      mask_q <= mask_i;
      base_q <= start_col_i;
      idx_q  <= '0;
    end else begin
      err_q <= 1'b0;
      if (term_i) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        if (at_end) act_q <= 1'b0;
        else        idx_q <= idx_q + COL_W'(1);  // wraps for page mode
      end
    end
  end

  assign act_o  = act_q;
  assign err_o  = err_q;
  assign last_o = act_q & at_end;
  assign full_o = full_q;
  assign ilv_o  = ilv_q;
  assign mask_o = mask_q;
  assign base_o = base_q;
  assign idx_o  = idx_q;

  // R9
  err_no_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !act_o);
  // R8
  term_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && !start_i |=> !act_o);
  // R3
  last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !act_o);
  // R9
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> !err_o);
endmodule

// File: rtl/col_order_map.sv
module col_order_map #(
  parameter int COL_W = 9
) (
  input  logic             ilv_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + idx_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic off;
    assign off      = ilv_i ? (base_i[b] ^ idx_i[b]) : sum[b];
    assign col_o[b] = mask_i[b] ? off : base_i[b];
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic             legal, full_d, full_q, ilv_q;
  logic [COL_W-1:0] mask_d, mask_q, base_q, idx_q;

  col_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .legal_o(legal),
    .full_o (full_d),
    .mask_o (mask_d)
  );

  col_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .term_i     (term_i),
    .legal_i    (legal),
    .full_i     (full_d),
    .ilv_i      (ilv_i),
    .mask_i     (mask_d),
    .start_col_i(start_col_i),
    .act_o      (valid_o),
    .err_o      (err_o),
    .last_o     (last_o),
    .full_o     (full_q),
    .ilv_o      (ilv_q),
    .mask_o     (mask_q),
    .base_o     (base_q),
    .idx_o      (idx_q)
  );

  col_order_map #(.COL_W(COL_W)) u_map (
    .ilv_i (ilv_q),
    .base_i(base_q),
    .idx_i (idx_q),
    .mask_i(mask_q),
    .col_o (col_o)
  );

  // R2
  start_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && legal |=> valid_o && (col_o == $past(start_col_i)));
  // R9
  bad_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !legal |=> err_o && !valid_o);
  // R7
  page_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q && !start_i && !term_i |=>
      valid_o && !last_o && (col_o == COL_W'($past(col_o) + 1'b1)));
  // R3
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: tb/sdram_col_seq_bench.sv
module sdram_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, ilv = 1'b0, term = 1'b0;
  logic [8:0] scol = '0;
  logic [2:0] code = '0;
  logic [8:0] col;
  logic       valid, last, err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  bit       m_act, m_err, m_full, m_ilv;
  int       m_n, m_idx;
  bit [8:0] m_base;

  always #2 clk = ~clk;

  sdram_col_seq u_sdram_col_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .len_code_i(code), .ilv_i(ilv), .term_i(term),
    .col_o(col), .valid_o(valid), .last_o(last), .err_o(err)
  );

  function automatic bit [8:0] exp_col(bit [8:0] b, int n, bit il, int i);
    bit [8:0] mk, off;
    mk  = 9'(n - 1);
    off = il ? (b ^ 9'(i)) : 9'(b + 9'(i));
    return (b & ~mk) | (off & mk);
  endfunction

  task automatic model_edge(bit s, bit t, bit [2:0] c, bit il, bit [8:0] sc);
    if (s) begin
      bit lg;
      lg     = (c <= 3'd3) || (c == 3'd7 && !il);
      m_act  = lg;
      m_err  = !lg;
      m_full = (c == 3'd7);
      m_n    = m_full ? 512 : (1 << c);
      m_ilv  = il;
      m_base = sc;
      m_idx  = 0;
    end else begin
      m_err = 0;
      if (t) m_act = 0;
      else if (m_act) begin
        if (!m_full && m_idx == m_n - 1) m_act = 0;
        else m_idx = (m_idx + 1) % 512;
      end
    end
  endtask

  task automatic compare(string tag);
    bit       e_last;
    bit [8:0] e_col;
    e_last = m_act && !m_full && (m_idx == m_n - 1);
    e_col  = exp_col(m_base, m_n, m_ilv, m_idx);
    n_chk++;
    if (valid !== m_act || last !== e_last || err !== m_err ||
        (m_act && col !== e_col)) begin
      n_bad++;
      $display("FAIL %s: v/l/e/col act %b%b%b %h exp %b%b%b %h",
               tag, valid, last, err, col, m_act, e_last, m_err, e_col);
    end
  endtask

  task automatic cyc(bit s, bit t, bit [2:0] c, bit il, bit [8:0] sc, string tag);
    @(negedge clk);
    start = s; term = t; code = c; ilv = il; scol = sc;
    @(posedge clk);
    model_edge(s, t, c, il, sc);
    #1;
    compare(tag);
  endtask

  task automatic idle(int k, string tag);
    for (int i = 0; i < k; i++) cyc(0, 0, 3'd0, 0, 9'd0, tag);
  endtask

  function automatic string rtag();
    if (m_err) return "R9";
    if (!m_act) return "R8";
    if (m_idx == 0 && m_n > 1) return "R2";
    if (m_full) return "R7";
    if (m_n == 1) return "R6";
    return m_ilv ? "R5" : "R4";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: act timeout exp completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    m_act = 0; m_err = 0; m_full = 0; m_ilv = 0; m_n = 1; m_idx = 0; m_base = 0;
    #9 rst_n = 1'b1;
    // R1 reset state
    idle(2, "R1");
    // R4 start 5 len 8 sequential
    cyc(1, 0, 3'd3, 0, 9'h0AD, "R2");
    idle(8, "R4");
    // R5 interleaved
    cyc(1, 0, 3'd3, 1, 9'h0AD, "R2");
    idle(8, "R5");
    cyc(1, 0, 3'd2, 1, 9'h13E, "R5");
    idle(4, "R5");
    // R6 length one ignores ordering bit
    cyc(1, 0, 3'd0, 1, 9'h1A3, "R6");
    idle(2, "R6");
    // R3 length 2 and 4 counts
    cyc(1, 0, 3'd1, 0, 9'h0F1, "R3");
    idle(3, "R3");
    cyc(1, 0, 3'd2, 0, 9'h002, "R3");
    idle(5, "R3");
    // R7 page wrap 510 -> 0, then R8 terminate
    cyc(1, 0, 3'd7, 0, 9'h1FE, "R7");
    idle(5, "R7");
    cyc(0, 1, 3'd0, 0, 9'd0, "R8");
    idle(1, "R8");
    cyc(0, 1, 3'd0, 0, 9'd0, "R8");   // term while idle: no effect
    // R9 illegal codes abort running burst
    cyc(1, 0, 3'd3, 0, 9'h010, "R2");
    cyc(1, 0, 3'd5, 0, 9'h011, "R9");
    idle(2, "R9");
    cyc(1, 0, 3'd7, 1, 9'h011, "R9");
    idle(1, "R9");
    // R10 restart; start beats terminate on same edge
    cyc(1, 0, 3'd7, 0, 9'h100, "R10");
    idle(3, "R10");
    cyc(1, 1, 3'd3, 1, 9'h047, "R10");
    idle(3, "R10");
    cyc(1, 0, 3'd2, 0, 9'h033, "R10");
    idle(5, "R10");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      bit s, t, il;
      bit [2:0] c;
      s  = (!m_act) ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 9) == 0);
      t  = ($urandom_range(0, 11) == 0);
      c  = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 3))
                                      : 3'($urandom_range(4, 7));
      if ($urandom_range(0, 5) == 0) c = 3'd7;
      il = 1'($urandom);
      if (c == 3'd7 && $urandom_range(0, 3) != 0) il = 0;
      @(negedge clk);
      start = s; term = t; code = c; ilv = il; scol = 9'($urandom);
      @(posedge clk);
      model_edge(s, t, c, il, scol);
      #1;
      compare((s && t) ? "R10" : rtag());
    end
    finish_run();
  end
endmodule